// File: doc/BRIEF.md
# Program Counter Sequencer with Flag-Tested Branches

This block holds the address of the instruction currently being executed and works out the address of the next one on every rising clock edge. Instructions sit one per address in consecutive locations. When the instruction does not change control flow, the address simply steps up by one. An unconditional jump always loads a supplied target address. A conditional branch loads the target only when a selected ALU status flag has the required value; otherwise the address steps up by one.

A decode stage outside this block provides three things each cycle: the control-flow kind, a 3-bit condition select and the target address. The four ALU status flags (overflow, carry, negative, zero) are also inputs. By default the block registers the flags itself, so a branch tests the flags produced by the previous ALU operation. Instruction memory and decode are not part of the block. The current address is the only output.

Top module: `pc_sequencer`

## Requirements
- R1: A synchronous active-high reset drives `pc_o` to 0 at the next rising edge and clears the stored flags to 0, so that a branch in the first cycle after reset sees V=C=N=Z=0.
- R2: With `flow_i` = 2'b00 (step), `pc_o` increases by exactly one at each rising edge, whatever the values of `cond_sel_i` and `target_i`.
- R3: Stepping is modulo 2^16: from 16'hFFFF, a step gives 16'h0000.
- R4: With `flow_i` = 2'b01 (jump), `pc_o` takes the value of `target_i` at the next edge, whatever the flags and `cond_sel_i`.
- R5: With `flow_i` = 2'b10 (branch), `pc_o` takes `target_i` when the condition holds. `cond_sel_i` = {flag[1:0], polarity}. The flag field codes are 0=V, 1=C, 2=N and 3=Z. Polarity 0 means the branch is taken when the flag is 1, and polarity 1 means it is taken when the flag is 0. This gives codes 0..7 = V set, V clear, C set, C clear, N set, N clear, Z set, Z clear.
- R6: A branch whose condition does not hold increments `pc_o` by one.
- R7: A branch tests the flag values that were present at the previous rising edge. Flag values applied in the same cycle as the branch have no effect on its outcome.
- R8: `flow_i` = 2'b11 is reserved and behaves exactly as a step. `target_i` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| flow_i | input | 2 | Control-flow kind: 00 step, 01 jump, 10 branch, 11 reserved (step) |
| cond_sel_i | input | 3 | Branch condition {flag[1:0], polarity} |
| target_i | input | 16 | Jump or branch destination address |
| flag_v_i | input | 1 | Overflow flag from the ALU |
| flag_c_i | input | 1 | Carry flag from the ALU |
| flag_n_i | input | 1 | Negative flag from the ALU |
| flag_z_i | input | 1 | Zero flag from the ALU |
| pc_o | output | 16 | Address of the current instruction |

## Verification
The address register drives `pc_o` directly, so a wrong address value shows up on the port in the cycle after the faulty edge. After that, every later step carries the error forward. A wrong value in the stored flags is silent until a branch selects that flag. It then shows as a taken branch where a fall-through was expected, or the reverse, one cycle after that branch. The bench therefore runs branches on every flag with both polarities, in both the set and clear state. It also changes the live flags in the branch cycle so that any lag error becomes visible.

// File: rtl/pcseq_pkg.sv
package pcseq_pkg;

   typedef enum logic [1:0] {
      FLOW_STEP   = 2'b00,
      FLOW_JUMP   = 2'b01,
      FLOW_BRANCH = 2'b10,
      FLOW_RSVD   = 2'b11
   } flow_e;

   typedef struct packed {
      logic v;
      logic c;
      logic n;
      logic z;
   } flags_t;

   localparam int SEL_W  = 3;
   localparam int FLAG_N = 4;

endpackage

// File: rtl/pcseq_flag_stage.sv
module pcseq_flag_stage
   import pcseq_pkg::*;
#(
   parameter bit REG_FLAGS = 1'b1
) (
   input  logic   clk,
   input  logic   rst,
   input  flags_t flags_i,
   output flags_t flags_o
);

   generate
      if (REG_FLAGS) begin : g_reg
         flags_t held_q;
         always_ff @(posedge clk) begin
            if (rst) held_q <= '0;
            else     held_q <= flags_i;
         end
         assign flags_o = held_q;
      end else begin : g_pass
         assign flags_o = flags_i;
      end
   endgenerate

endmodule

// File: rtl/pcseq_cond_eval.sv
module pcseq_cond_eval
   import pcseq_pkg::*;
(
   input  flags_t             flags_i,
   input  logic [SEL_W-1:0]   sel_i,
   output logic               taken_o
);

   localparam int IDX_W = $clog2(FLAG_N);

   logic [FLAG_N-1:0] flag_vec;
   logic [IDX_W-1:0]  flag_idx;
   logic              polarity;
   logic              picked;

   assign flag_vec = {flags_i.z, flags_i.n, flags_i.c, flags_i.v};
   assign flag_idx = sel_i[SEL_W-1:1];
   assign polarity = sel_i[0];
   assign picked   = flag_vec[flag_idx];
   assign taken_o  = picked ^ polarity;

endmodule

// File: rtl/pcseq_next_addr.sv
module pcseq_next_addr
   import pcseq_pkg::*;
#(
   parameter int PC_W = 16
) (
   input  logic [PC_W-1:0] pc_i,
   input  logic [PC_W-1:0] target_i,
   input  flow_e           flow_i,
   input  logic            taken_i,
   output logic [PC_W-1:0] next_o
);

   localparam logic [PC_W-1:0] STEP = PC_W'(1);

   logic [PC_W-1:0] seq_addr;
   logic            load_target;

   assign seq_addr = pc_i + STEP;

   always_comb begin
      unique case (flow_i)
         FLOW_JUMP:   load_target = 1'b1;
         FLOW_BRANCH: load_target = taken_i;
         default:     load_target = 1'b0;
      endcase
   end

   assign next_o = load_target ? target_i : seq_addr;

endmodule

// File: rtl/pc_sequencer.sv
module pc_sequencer
   import pcseq_pkg::*;
#(
   parameter int              PC_W       = 16,
   parameter logic [PC_W-1:0] RESET_ADDR = '0,
   parameter bit              REG_FLAGS  = 1'b1
) (
   input  logic            clk,
   input  logic            rst,
   input  logic [1:0]      flow_i,
   input  logic [2:0]      cond_sel_i,
   input  logic [PC_W-1:0] target_i,
   input  logic            flag_v_i,
   input  logic            flag_c_i,
   input  logic            flag_n_i,
   input  logic            flag_z_i,
   output logic [PC_W-1:0] pc_o
);

   generate
      if (PC_W < 2) begin : g_bad_width
         $error("pc_sequencer: PC_W must be at least 2");
      end
   endgenerate

   flags_t          live_flags;
   flags_t          used_flags;
   flow_e           flow;
   logic            taken;
   logic [PC_W-1:0] pc_q;
   logic [PC_W-1:0] pc_d;

   assign live_flags = '{v: flag_v_i, c: flag_c_i, n: flag_n_i, z: flag_z_i};
   assign flow       = flow_e'(flow_i);

   pcseq_flag_stage #(.REG_FLAGS(REG_FLAGS)) u_flags (
      .clk     (clk),
      .rst     (rst),
      .flags_i (live_flags),
      .flags_o (used_flags)
   );

   pcseq_cond_eval u_cond (
      .flags_i (used_flags),
      .sel_i   (cond_sel_i),
      .taken_o (taken)
   );

   pcseq_next_addr #(.PC_W(PC_W)) u_next (
      .pc_i     (pc_q),
      .target_i (target_i),
      .flow_i   (flow),
      .taken_i  (taken),
      .next_o   (pc_d)
   );

   always_ff @(posedge clk) begin
      if (rst) pc_q <= RESET_ADDR;
      else     pc_q <= pc_d;
   end

   assign pc_o = pc_q;

endmodule

// File: rtl/pcseq_checker.sv
module pcseq_checker #(
   parameter int PC_W      = 16,
   parameter bit REG_FLAGS = 1'b1
) (
   input logic            clk,
   input logic            rst,
   input logic [1:0]      flow_i,
   input logic [2:0]      cond_sel_i,
   input logic [PC_W-1:0] target_i,
   input logic            flag_v_i,
   input logic            flag_c_i,
   input logic            flag_n_i,
   input logic            flag_z_i,
   input logic [PC_W-1:0] pc_o
);

   logic pv, pc_f, pn, pz;
   logic sv, sc, sn, sz;
   logic expect_take;

   always_ff @(posedge clk) begin
      if (rst) {pv, pc_f, pn, pz} <= 4'b0000;
      else     {pv, pc_f, pn, pz} <= {flag_v_i, flag_c_i, flag_n_i, flag_z_i};
   end

   assign {sv, sc, sn, sz} = REG_FLAGS ? {pv, pc_f, pn, pz}
                                       : {flag_v_i, flag_c_i, flag_n_i, flag_z_i};

   always_comb begin
      case (cond_sel_i)
         3'd0:    expect_take =  sv;
         3'd1:    expect_take = !sv;
         3'd2:    expect_take =  sc;
         3'd3:    expect_take = !sc;
         3'd4:    expect_take =  sn;
         3'd5:    expect_take = !sn;
         3'd6:    expect_take =  sz;
         default: expect_take = !sz;
      endcase
   end

   a_r2_step_increments: assert property (@(posedge clk) disable iff (rst)
      (flow_i == 2'b00) |=> (pc_o == PC_W'($past(pc_o) + 1'b1)));

   a_r3_wraps_to_zero: assert property (@(posedge clk) disable iff (rst)
      (flow_i == 2'b00 && pc_o == {PC_W{1'b1}}) |=> (pc_o == '0));

   a_r4_jump_loads: assert property (@(posedge clk) disable iff (rst)
      (flow_i == 2'b01) |=> (pc_o == $past(target_i)));

   a_r5_branch_taken: assert property (@(posedge clk) disable iff (rst)
      (flow_i == 2'b10 && expect_take) |=> (pc_o == $past(target_i)));

   a_r6_branch_falls_through: assert property (@(posedge clk) disable iff (rst)
      (flow_i == 2'b10 && !expect_take) |=> (pc_o == PC_W'($past(pc_o) + 1'b1)));

   a_r8_reserved_steps: assert property (@(posedge clk) disable iff (rst)
      (flow_i == 2'b11) |=> (pc_o == PC_W'($past(pc_o) + 1'b1)));

endmodule

bind pc_sequencer pcseq_checker #(.PC_W(PC_W), .REG_FLAGS(REG_FLAGS)) u_pcseq_chk (
   .clk        (clk),
   .rst        (rst),
   .flow_i     (flow_i),
   .cond_sel_i (cond_sel_i),
   .target_i   (target_i),
   .flag_v_i   (flag_v_i),
   .flag_c_i   (flag_c_i),
   .flag_n_i   (flag_n_i),
   .flag_z_i   (flag_z_i),
   .pc_o       (pc_o)
);

// File: tb/pc_sequencer_bench.sv
`timescale 1ns/1ps
module pc_sequencer_bench;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [1:0]  flow_i = 2'b00;
   logic [2:0]  cond_sel_i = 3'd0;
   logic [15:0] target_i = 16'h0;
   logic        flag_v_i = 1'b0, flag_c_i = 1'b0, flag_n_i = 1'b0, flag_z_i = 1'b0;
   logic [15:0] pc_o;

   int total = 0;
   int bad   = 0;

   // reference state
   int model_pc = 0;
   bit mv = 0, mc = 0, mn = 0, mz = 0;

   always #2.5 clk = ~clk;

   pc_sequencer u_pc_sequencer (
      .clk(clk), .rst(rst), .flow_i(flow_i), .cond_sel_i(cond_sel_i),
      .target_i(target_i), .flag_v_i(flag_v_i), .flag_c_i(flag_c_i),
      .flag_n_i(flag_n_i), .flag_z_i(flag_z_i), .pc_o(pc_o)
   );

   function automatic bit cond_true(int sel, bit v, bit c, bit n, bit z);
      bit f;
      case (sel / 2)
         0: f = v;
         1: f = c;
         2: f = n;
         default: f = z;
      endcase
      return (sel % 2 == 1) ? !f : f;
   endfunction

   task automatic check(string req, int exp);
      total++;
      if (int'(pc_o) != exp) begin
         bad++;
         $display("FAIL %s: pc=%04h expected=%04h", req, pc_o, exp[15:0]);
      end
   endtask

   // Drives one cycle (called just after a falling edge), checks after the next rise.
   task automatic step(string req, int fl, int sel, int tgt, bit v, bit c, bit n, bit z);
      int exp;
      flow_i = 2'(fl); cond_sel_i = 3'(sel); target_i = 16'(tgt);
      flag_v_i = v; flag_c_i = c; flag_n_i = n; flag_z_i = z;
      if (fl == 1)
         exp = tgt;
      else if (fl == 2 && cond_true(sel, mv, mc, mn, mz))
         exp = tgt;
      else
         exp = (model_pc + 1) % 65536;
      @(negedge clk);
      model_pc = exp;
      mv = v; mc = c; mn = n; mz = z;
      check(req, exp);
   endtask

   task automatic do_reset(bit v, bit c, bit n, bit z);
      rst = 1'b1;
      flag_v_i = v; flag_c_i = c; flag_n_i = n; flag_z_i = z;
      flow_i = 2'b01; target_i = 16'h5A5A;
      repeat (3) @(negedge clk);
      model_pc = 0; mv = 0; mc = 0; mn = 0; mz = 0;
      check("R1", 0);
      rst = 1'b0;
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin : main
      @(negedge clk);
      do_reset(1, 1, 1, 1);

      // R2: plain stepping with junk on target and select
      for (int i = 0; i < 5; i++) step("R2", 0, i, 16'h1234 + i, 0, 0, 0, 0);

      // R4 then R3: jump near the top and wrap
      step("R4", 1, 3'd7, 16'hFFFE, 1, 1, 1, 1);
      step("R3", 0, 0, 0, 0, 0, 0, 0);
      step("R3", 0, 0, 0, 0, 0, 0, 0);
      step("R3", 0, 0, 0, 0, 0, 0, 0);

      // R5/R6/R7: each condition with its flag set and clear; live flags inverted
      for (int sel = 0; sel < 8; sel++) begin
         for (int s = 0; s < 2; s++) begin
            bit [3:0] f;
            f = '0;
            f[3 - sel / 2] = s[0];
            step("R2", 0, 0, 0, f[3], f[2], f[1], f[0]);
            step(cond_true(sel, f[3], f[2], f[1], f[0]) ? "R5" : "R6",
                 2, sel, 16'h0100 * (sel + 1) + s, ~f[3], ~f[2], ~f[1], ~f[0]);
         end
      end

      // R7: Z set in branch cycle only; previous Z clear -> BZ falls through
      step("R7", 0, 0, 0, 0, 0, 0, 0);
      step("R7", 2, 6, 16'hBEEF, 0, 0, 0, 1);
      step("R7", 2, 6, 16'hCAFE, 0, 0, 0, 0);

      // R8: reserved flow steps and ignores target
      step("R8", 3, 0, 16'h7777, 1, 1, 1, 1);
      step("R8", 3, 7, 16'h0000, 0, 0, 0, 0);

      // R1: reset clears stored flags; branch on V clear is taken right after
      do_reset(1, 1, 1, 1);
      step("R1", 2, 1, 16'h4321, 1, 1, 1, 1);
      do_reset(1, 1, 1, 1);
      step("R1", 2, 0, 16'h4321, 1, 1, 1, 1);

      // mixed stream against the model
      for (int i = 0; i < 400; i++) begin
         int fl;
         int sel;
         fl  = int'($urandom_range(0, 3));
         sel = int'($urandom_range(0, 7));
         step(fl == 1 ? "R4" : (fl == 2 ? "R5" : (fl == 3 ? "R8" : "R2")),
              fl, sel, int'($urandom_range(0, 65535)),
              1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
      end

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule